// File: doc/BRIEF.md
# Z-Axis PI Height Controller with Anti-Windup

This block closes the height loop of a scanning probe. On every sample strobe it picks one of two reference sources: the demodulated oscillation amplitude or an externally digitised value. It subtracts a user setpoint to form an error and runs a proportional-plus-integral law to produce the Z drive word. The output is clamped to a programmable window. The integrator is held whenever the output already sits on a limit and the new increment would push it further into that limit.

While the enable is low, the output is forced to a user hold constant on every clock. On the first strobe after the loop is enabled again, the integrator is preloaded so that the output continues from the hold constant instead of jumping.

Top module: `z_pi_ctrl`

## Requirements
- R1: While rst_ni is low, z_o is 0.
- R2: On every clock edge at which enable_i is low, z_o takes the value of hold_i.
- R3: The reference is amp_i when src_sel_i is 0 and ext_i when src_sel_i is 1. The error is the reference minus setpoint_i.
- R4: z_o changes only at a clock edge where sample_i and enable_i are both high, or where enable_i is low. With enable_i high and sample_i low, z_o is held.
- R5: The gains kp_i and ki_i are signed Q8.8. The proportional term is floor(err*kp_i/256) and the integral increment is floor(err*ki_i/256). The unclamped output is the proportional term plus the updated accumulator.
- R6: The output is clamped to the range zmin_i to zmax_i, assuming zmin_i <= zmax_i.
- R7: On a strobe, the accumulator is not updated if z_o equals zmax_i and the increment is positive, or if z_o equals zmin_i and the increment is negative. In every other case the increment is added.
- R8: On the first strobe after enable_i rises, the accumulator is loaded with hold_i minus the proportional term. z_o therefore equals hold_i, clamped to the limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Sample strobe, one loop update per high cycle |
| amp_i | input | 16 | Demodulated amplitude reference, signed |
| ext_i | input | 16 | External reference, signed |
| src_sel_i | input | 1 | Reference select: 0 amplitude, 1 external |
| setpoint_i | input | 16 | Tracking target, signed |
| kp_i | input | 16 | Proportional gain, signed Q8.8 |
| ki_i | input | 16 | Integral gain, signed Q8.8 |
| zmin_i | input | 16 | Lower output limit, signed |
| zmax_i | input | 16 | Upper output limit, signed |
| hold_i | input | 16 | Output value while the loop is off, signed |
| enable_i | input | 1 | Feedback enable |
| z_o | output | 16 | Z drive word, signed |

## Verification
Some properties are checked by assertions on every cycle:
- the output follows the hold value while the loop is off;
- the output is stable between strobes;
- the output stays inside the limit window after each update;
- the first enabled strobe reproduces the hold value;
- the accumulator stays unchanged when an increment is blocked at a limit.

Other behaviour can only be shown by the bench's sweeps, which compare z_o against an arithmetic model:
- the exact arithmetic of the two gain terms;
- the choice of reference source;
- the integrator's recovery from a limit once the error reverses sign.

// File: rtl/z_pi_pkg.sv
package z_pi_pkg;
  typedef enum logic {
    SRC_AMP = 1'b0,
    SRC_EXT = 1'b1
  } z_src_e;
  localparam int unsigned Z_FRAC = 8;
endpackage

// File: rtl/z_err_path.sv
module z_err_path
  import z_pi_pkg::*;
#(
  parameter  int DW   = 16,
  parameter  int GW   = 16,
  parameter  int FRAC = 8,
  localparam int PW   = DW + 1 + GW - FRAC
) (
  input  logic signed [DW-1:0] amp_i,
  input  logic signed [DW-1:0] ext_i,
  input  logic                 sel_i,
  input  logic signed [DW-1:0] setpoint_i,
  input  logic signed [GW-1:0] kp_i,
  input  logic signed [GW-1:0] ki_i,
  output logic signed [PW-1:0] p_term_o,
  output logic signed [PW-1:0] i_step_o
);
  localparam int EW = DW + 1;
  localparam int MW = EW + GW;

  logic signed [DW-1:0] ref_s;
  logic signed [EW-1:0] err;
  logic signed [MW-1:0] prod_p, prod_i;

  // R3
  assign ref_s  = (z_src_e'(sel_i) == SRC_EXT) ? ext_i : amp_i;
  assign err    = EW'(ref_s) - EW'(setpoint_i);
  assign prod_p = MW'(err) * MW'(kp_i);
  assign prod_i = MW'(err) * MW'(ki_i);
  // dropping low bits of a two's complement product is a floor divide
  assign p_term_o = prod_p[MW-1:FRAC];
  assign i_step_o = prod_i[MW-1:FRAC];
endmodule

// File: rtl/z_integ.sv
module z_integ #(
  parameter int PW = 25,
  parameter int IW = 29
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 step_i,
  input  logic                 preload_i,
  input  logic signed [IW-1:0] preload_val_i,
  input  logic signed [PW-1:0] inc_i,
  input  logic                 at_max_i,
  input  logic                 at_min_i,
  output logic signed [IW-1:0] acc_d_o
);
  logic signed [IW-1:0] acc_q;
  logic signed [IW:0]   sum_w;
  logic signed [IW-1:0] sum_sat;
  logic                 freeze;

  assign freeze = (at_max_i && (inc_i > 0)) || (at_min_i && (inc_i < 0));
  assign sum_w  = (IW+1)'(acc_q) + (IW+1)'(inc_i);

  always_comb begin
    if (sum_w[IW] != sum_w[IW-1])
      sum_sat = sum_w[IW] ? {1'b1, {(IW-1){1'b0}}} : {1'b0, {(IW-1){1'b1}}};
    else
      sum_sat = sum_w[IW-1:0];
  end

  always_comb begin
    if (!step_i)        acc_d_o = acc_q;
    else if (preload_i) acc_d_o = preload_val_i;
    else if (freeze)    acc_d_o = acc_q;
    else                acc_d_o = sum_sat;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d_o;
  end

  // R7
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !preload_i && freeze) |=> $stable(acc_q));
endmodule

// File: rtl/z_out_clamp.sv
module z_out_clamp #(
  parameter int DW = 16,
  parameter int PW = 25,
  parameter int IW = 29
) (
  input  logic signed [PW-1:0] p_i,
  input  logic signed [IW-1:0] acc_i,
  input  logic signed [DW-1:0] zmin_i,
  input  logic signed [DW-1:0] zmax_i,
  output logic signed [DW-1:0] z_o
);
  logic signed [IW:0] sum_w;

  assign sum_w = (IW+1)'(acc_i) + (IW+1)'(p_i);

  // R6
  always_comb begin
    if (sum_w > (IW+1)'(zmax_i))      z_o = zmax_i;
    else if (sum_w < (IW+1)'(zmin_i)) z_o = zmin_i;
    else                              z_o = sum_w[DW-1:0];
  end
endmodule

// File: rtl/z_pi_ctrl.sv
module z_pi_ctrl #(
  parameter int DW   = 16,
  parameter int GW   = 16,
  parameter int FRAC = z_pi_pkg::Z_FRAC
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sample_i,
  input  logic signed [DW-1:0] amp_i,
  input  logic signed [DW-1:0] ext_i,
  input  logic                 src_sel_i,
  input  logic signed [DW-1:0] setpoint_i,
  input  logic signed [GW-1:0] kp_i,
  input  logic signed [GW-1:0] ki_i,
  input  logic signed [DW-1:0] zmin_i,
  input  logic signed [DW-1:0] zmax_i,
  input  logic signed [DW-1:0] hold_i,
  input  logic                 enable_i,
  output logic signed [DW-1:0] z_o
);
  localparam int PW = DW + 1 + GW - FRAC;
  localparam int IW = PW + 4;

  logic signed [PW-1:0] p_term, i_step;
  logic signed [IW-1:0] acc_d, preload_val;
  logic signed [DW-1:0] z_d, z_q;
  logic                 active_q, step;

  z_err_path #(.DW(DW), .GW(GW), .FRAC(FRAC)) u_err (
    .amp_i(amp_i), .ext_i(ext_i), .sel_i(src_sel_i), .setpoint_i(setpoint_i),
    .kp_i(kp_i), .ki_i(ki_i), .p_term_o(p_term), .i_step_o(i_step)
  );

  assign step        = sample_i && enable_i;
  // R8: integrator preload for bumpless re-entry
  assign preload_val = IW'(hold_i) - IW'(p_term);

  z_integ #(.PW(PW), .IW(IW)) u_integ (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .preload_i(!active_q),
    .preload_val_i(preload_val), .inc_i(i_step),
    .at_max_i(z_q == zmax_i), .at_min_i(z_q == zmin_i), .acc_d_o(acc_d)
  );

  z_out_clamp #(.DW(DW), .PW(PW), .IW(IW)) u_clamp (
    .p_i(p_term), .acc_i(acc_d), .zmin_i(zmin_i), .zmax_i(zmax_i), .z_o(z_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      z_q      <= '0;
      active_q <= 1'b0;
    end else if (!enable_i) begin
      z_q      <= hold_i;
      active_q <= 1'b0;
    end else if (sample_i) begin
      z_q      <= z_d;
      active_q <= 1'b1;
    end
  end

  assign z_o = z_q;

  // R2
  hold_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (z_o == $past(hold_i)));
  // R4
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !sample_i) |=> $stable(z_o));
  // R6
  z_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && (zmin_i <= zmax_i)) |=> ((z_o >= $past(zmin_i)) && (z_o <= $past(zmax_i))));
  // R8
  bumpless_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !active_q && (hold_i >= zmin_i) && (hold_i <= zmax_i)) |=> (z_o == $past(hold_i)));
endmodule

// File: tb/tb_z_pi_ctrl.sv
`timescale 1ns/1ps
module tb_z_pi_ctrl;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample = 1'b0, sel = 1'b0, enable = 1'b0;
  logic signed [DW-1:0] amp = '0, ext = '0, sp = '0, kp = '0, ki = '0;
  logic signed [DW-1:0] zmin = -16'sd200, zmax = 16'sd300, hold = '0;
  logic signed [DW-1:0] z;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  longint m_z = 0, m_acc = 0;
  bit m_act = 1'b0;

  always #5 clk = ~clk;

  z_pi_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .amp_i(amp), .ext_i(ext),
    .src_sel_i(sel), .setpoint_i(sp), .kp_i(kp), .ki_i(ki), .zmin_i(zmin),
    .zmax_i(zmax), .hold_i(hold), .enable_i(enable), .z_o(z)
  );

  task automatic chk(string req, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // arithmetic model of one enabled strobe
  task automatic model_step();
    longint r, e, p, inc, s;
    r   = sel ? longint'(ext) : longint'(amp);
    e   = r - longint'(sp);
    p   = (e * longint'(kp)) >>> 8;
    inc = (e * longint'(ki)) >>> 8;
    if (!m_act) begin
      m_acc = longint'(hold) - p;
      m_act = 1'b1;
    end else if (!((m_z == zmax && inc > 0) || (m_z == zmin && inc < 0))) begin
      m_acc = m_acc + inc;
    end
    s = p + m_acc;
    if (s > zmax)      m_z = zmax;
    else if (s < zmin) m_z = zmin;
    else               m_z = s;
  endtask

  task automatic strobe(int a, int x, bit sl, int setp, string req);
    @(negedge clk);
    amp = DW'(a); ext = DW'(x); sel = sl; sp = DW'(setp);
    enable = 1'b1; sample = 1'b1;
    @(negedge clk);
    sample = 1'b0;
    model_step();
    chk(req, z, m_z);
  endtask

  task automatic loop_off(int h);
    @(negedge clk);
    enable = 1'b0; hold = DW'(h);
    @(negedge clk);
    chk("R2", z, h);
    m_z = h; m_act = 1'b0;
  endtask

  task automatic idle_check();
    @(negedge clk);
    amp = amp + 16'sd7;
    @(negedge clk);
    chk("R4", z, m_z);
  endtask

  initial begin
    int kps[5] = '{0, 128, 256, -64, 384};
    int kis[4] = '{0, 32, 256, -128};
    repeat (3) @(negedge clk);
    chk("R1", z, 0);
    rst_n = 1'b1;

    // R8: first enabled strobe reproduces the hold value
    kp = 16'sd256; ki = 16'sd64;
    loop_off(77);
    strobe(50, 0, 1'b0, 10, "R8");
    chk("R8", z, 77);

    // R3: select between amplitude and external sources
    ki = 16'sd0;
    loop_off(0);
    strobe(20, 0, 1'b0, 20, "R3");
    strobe(100, -50, 1'b1, 20, "R3");
    chk("R3", z, -70);
    idle_check();

    // R6: clamp at both limits
    loop_off(0);
    strobe(0, 0, 1'b0, 0, "R6");
    strobe(400, 0, 1'b0, 0, "R6");
    chk("R6", z, 300);
    strobe(-400, 0, 1'b0, 0, "R6");
    chk("R6", z, -200);

    // R7: anti-windup at upper limit, then recovery
    kp = 16'sd0; ki = 16'sd256; zmin = -16'sd500; zmax = 16'sd100;
    loop_off(0);
    strobe(50, 0, 1'b0, 0, "R7");
    strobe(50, 0, 1'b0, 0, "R7");
    strobe(50, 0, 1'b0, 0, "R7");
    strobe(50, 0, 1'b0, 0, "R7");
    strobe(50, 0, 1'b0, 0, "R7");
    chk("R7", z, 100);
    strobe(-10, 0, 1'b0, 0, "R7");
    chk("R7", z, 90);

    // sweep of sources, gains and error patterns
    zmin = -16'sd200; zmax = 16'sd300;
    for (int sl = 0; sl < 2; sl++) begin
      foreach (kis[i]) begin
        foreach (kps[j]) begin
          kp = DW'(kps[j]); ki = DW'(kis[i]);
          loop_off((kps[j] + kis[i] * 3) % 150);
          for (int s = 0; s < 10; s++) begin
            int a, x;
            a = ((s * 53 + kps[j]) % 97) - 20;
            x = ((s * 29 + kis[i]) % 83) - 15;
            if (s >= 5) begin a = -a * 2; x = -x * 2; end
            strobe(a, x, sl[0], 10 * sl - 5, "R3/R5/R6/R7");
          end
          idle_check();
        end
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule